// File: doc/BRIEF.md
# SIMD Byte Table Lookup Unit

This block resolves eight byte-wide table indices against a byte table held in a vector register file of 32 registers, each 128 bits wide. The table is one to four registers long. It starts at a chosen register and wraps from the last register of the file back to register 0. The block reads the file through a single read port that delivers one 64-bit half-register per cycle. It therefore works through the eight indices one per cycle, starting with the least significant byte.

Each result byte is either the table byte that its index selects or, when the index falls outside the table, the byte at the same position of an initial vector that the caller supplies. An all-zero initial vector gives the lookup form, which clears missing bytes. Passing the current destination contents gives the extend form, which leaves missing bytes untouched. A 128-bit index vector is handled by issuing the operation twice.

The controller has three states:
- `ST_IDLE` waits for a start strobe.
- `ST_RUN` processes lane 0 through lane 7, one per cycle.
- `ST_DONE` raises the done pulse for one cycle.

The transitions are:
- start: `ST_IDLE` to `ST_RUN`.
- last lane: `ST_RUN` to `ST_DONE`, after lane 7.
- retire: `ST_DONE` to `ST_IDLE`.

Top module: `vtbl_lookup_unit`

## Requirements
- R1: A start strobe sampled in `ST_IDLE` latches the index vector, initial vector, base register and register count, and `busy_o` goes high the next cycle. A start strobe while busy is ignored and does not alter the result.
- R2: Lanes are processed one per cycle from lane 0 (bits 7:0) to lane 7 (bits 63:56). `done_o` is a one-cycle pulse in the eighth cycle after the start edge, and the block then returns to idle.
- R3: The register-count field encodes 0→1, 1→2, 2→3 and 3→4 registers. An index is in range exactly when it is below 16 × (registers).
- R4: For an in-range index, the read address is (2 × base + index[7:3]) mod 64, so the table wraps from register 31 to register 0. The byte taken from the returned word is number index[2:0], at bits index[2:0]×8 upward.
- R5: A lane whose index is out of range keeps the byte of the initial vector at the same position. Zeros give the lookup form and destination bytes give the extend form.
- R6: An in-range lookup writes only the result byte of the lane whose index produced it.
- R7: Index 255 is out of range for every register count.
- R8: `rf_rd_en_o` is high only in cycles that process an in-range lane, so the number of read cycles per operation equals the number of in-range lanes.
- R9: `result_o` holds its value from `done_o` until the next accepted start.
- R10: After reset the block is idle, with `busy_o`, `done_o` and `rf_rd_en_o` low and `result_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe |
| index_i | input | 64 | Eight byte indices |
| init_i | input | 64 | Initial result vector |
| base_reg_i | input | 5 | First table register |
| reg_cnt_i | input | 2 | Table length minus one, in registers |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result vector |
| rf_rd_en_o | output | 1 | Register file read request |
| rf_rd_addr_o | output | 6 | 64-bit element address |
| rf_rd_data_i | input | 64 | Element returned in the same cycle |

## Verification
The embedded assertions check the per-cycle sequencing on every cycle:
- the lane counter steps by one;
- the done pulse follows the last lane and lasts a single cycle;
- result bytes of lanes that are not being written stay unchanged;
- the result stays frozen while idle;
- the decoder never accepts an index of 255 or one beyond four registers.

Only the bench scenarios can show that the right table bytes arrive in the right lanes. This covers:
- the wrap from register 31 to register 0;
- the exact range boundary for each register count;
- the difference between the lookup and extend forms;
- that a start strobe during an operation leaves the result alone.

// File: rtl/vtbl_pkg.sv
package vtbl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } vtbl_state_e;
endpackage

// File: rtl/vtbl_ctrl.sv
module vtbl_ctrl
    import vtbl_pkg::*;
#(
    parameter int LANES     = 8,
    parameter int LANE_BITS = $clog2(LANES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    output logic                 load_o,
    output logic                 active_o,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [LANE_BITS-1:0] lane_o
);
    localparam logic [LANE_BITS-1:0] LAST_LANE = LANE_BITS'(LANES - 1);

    vtbl_state_e         state_q, state_d;
    logic [LANE_BITS-1:0] lane_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_RUN;
            ST_RUN:  if (lane_q == LAST_LANE) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lane_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_RUN) lane_q <= lane_q + 1'b1;
            else                   lane_q <= '0;
        end
    end

    always_comb begin
        load_o   = 1'b0;
        active_o = 1'b0;
        busy_o   = 1'b0;
        done_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: load_o = start_i;
            ST_RUN: begin
                active_o = 1'b1;
                busy_o   = 1'b1;
            end
            ST_DONE: begin
                busy_o = 1'b1;
                done_o = 1'b1;
            end
            default: ;
        endcase
    end
    assign lane_o = lane_q;

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_last_lane_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && lane_o == LAST_LANE) |=> done_o);
    assert_lane_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && lane_o != LAST_LANE) |=> (active_o && lane_o == $past(lane_o) + 1'b1));
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (busy_o && lane_o == '0));
endmodule

// File: rtl/vtbl_lane_decode.sv
module vtbl_lane_decode #(
    parameter int IDX_W      = 8,
    parameter int BASE_W     = 5,
    parameter int CNT_W      = 2,
    parameter int REG_BYTES  = 16,
    parameter int ELEM_BYTES = 8,
    parameter int ELEM_W     = BASE_W + 1,
    parameter int OFF_W      = $clog2(ELEM_BYTES)
) (
    input  logic [IDX_W-1:0]  idx_i,
    input  logic [BASE_W-1:0] base_i,
    input  logic [CNT_W-1:0]  cnt_i,
    output logic              in_range_o,
    output logic [ELEM_W-1:0] elem_o,
    output logic [OFF_W-1:0]  off_o
);
    localparam int MAX_SPAN = REG_BYTES * (1 << CNT_W);

    logic [IDX_W:0] span;

    always_comb begin
        span       = (IDX_W+1)'((int'(cnt_i) + 1) * REG_BYTES);
        in_range_o = {1'b0, idx_i} < span;
        elem_o     = ELEM_W'({base_i, 1'b0}) + ELEM_W'(idx_i >> OFF_W);
        off_o      = idx_i[OFF_W-1:0];
    end

    always_comb begin
        if (idx_i == '1)
            assert_max_index_out_R7: assert (!in_range_o);
        if (in_range_o)
            assert_span_cap_R3: assert (int'(idx_i) < MAX_SPAN);
    end
endmodule

// File: rtl/vtbl_result_merge.sv
module vtbl_result_merge #(
    parameter int LANES     = 8,
    parameter int BYTE_W    = 8,
    parameter int LANE_BITS = $clog2(LANES),
    parameter int VEC_W     = LANES * BYTE_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_i,
    input  logic [VEC_W-1:0]     init_i,
    input  logic                 wr_i,
    input  logic [LANE_BITS-1:0] lane_i,
    input  logic [BYTE_W-1:0]    byte_i,
    output logic [VEC_W-1:0]     result_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] byte_q;
        logic              hit;
        assign hit = wr_i && (lane_i == LANE_BITS'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      byte_q <= '0;
            else if (load_i) byte_q <= init_i[g*BYTE_W +: BYTE_W];
            else if (hit)    byte_q <= byte_i;
        end
        assign result_o[g*BYTE_W +: BYTE_W] = byte_q;

        assert_lane_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (!load_i && !(wr_i && lane_i == LANE_BITS'(g))) |=> $stable(result_o[g*BYTE_W +: BYTE_W]));
    end
endmodule

// File: rtl/vtbl_lookup_unit.sv
module vtbl_lookup_unit #(
    parameter int LANES      = 8,
    parameter int BYTE_W     = 8,
    parameter int BASE_W     = 5,
    parameter int CNT_W      = 2,
    parameter int REG_BYTES  = 16,
    parameter int ELEM_BYTES = 8,
    parameter int VEC_W      = LANES * BYTE_W,
    parameter int ELEM_W     = BASE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VEC_W-1:0]  index_i,
    input  logic [VEC_W-1:0]  init_i,
    input  logic [BASE_W-1:0] base_reg_i,
    input  logic [CNT_W-1:0]  reg_cnt_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [VEC_W-1:0]  result_o,
    output logic              rf_rd_en_o,
    output logic [ELEM_W-1:0] rf_rd_addr_o,
    input  logic [VEC_W-1:0]  rf_rd_data_i
);
    localparam int LANE_BITS = $clog2(LANES);
    localparam int OFF_W     = $clog2(ELEM_BYTES);

    logic                 load, active;
    logic [LANE_BITS-1:0] lane;
    logic [VEC_W-1:0]     idx_q;
    logic [BASE_W-1:0]    base_q;
    logic [CNT_W-1:0]     cnt_q;
    logic [BYTE_W-1:0]    cur_idx, rd_byte;
    logic                 in_range;
    logic [ELEM_W-1:0]    elem;
    logic [OFF_W-1:0]     off;

    vtbl_ctrl #(.LANES(LANES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .load_o(load),
        .active_o(active), .busy_o(busy_o), .done_o(done_o), .lane_o(lane)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q  <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (load) begin
            idx_q  <= index_i;
            base_q <= base_reg_i;
            cnt_q  <= reg_cnt_i;
        end
    end

    assign cur_idx = idx_q[lane*BYTE_W +: BYTE_W];

    vtbl_lane_decode #(
        .IDX_W(BYTE_W), .BASE_W(BASE_W), .CNT_W(CNT_W),
        .REG_BYTES(REG_BYTES), .ELEM_BYTES(ELEM_BYTES)
    ) u_dec (
        .idx_i(cur_idx), .base_i(base_q), .cnt_i(cnt_q),
        .in_range_o(in_range), .elem_o(elem), .off_o(off)
    );

    assign rf_rd_en_o   = active && in_range;
    assign rf_rd_addr_o = rf_rd_en_o ? elem : '0;
    assign rd_byte      = rf_rd_data_i[off*BYTE_W +: BYTE_W];

    vtbl_result_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) u_merge (
        .clk(clk), .rst_n(rst_n), .load_i(load), .init_i(init_i),
        .wr_i(rf_rd_en_o), .lane_i(lane), .byte_i(rd_byte), .result_o(result_o)
    );

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(result_o));
    assert_rd_in_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rf_rd_en_o |-> (busy_o && !done_o));
endmodule

// File: tb/vtbl_lookup_unit_tb_top.sv
module vtbl_lookup_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] index_i = '0, init_i = '0;
    logic [4:0]  base_reg_i = '0;
    logic [1:0]  reg_cnt_i = '0;
    logic        busy_o, done_o, rf_rd_en_o;
    logic [63:0] result_o, rf_rd_data_i;
    logic [5:0]  rf_rd_addr_o;

    logic [63:0] rf_mem [64];
    int checks = 0, fails = 0, cyc = 0, start_cyc = 0, rd_cnt = 0;

    typedef struct { logic [63:0] res; int nvalid; } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    always @(posedge clk) if (rf_rd_en_o) rd_cnt <= rd_cnt + 1;
    assign rf_rd_data_i = rf_rd_en_o ? rf_mem[rf_rd_addr_o] : 64'h0;

    vtbl_lookup_unit dut_i (.*);

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [63:0] ix, input logic [63:0] ini,
                                   input logic [4:0] b, input logic [1:0] c);
        exp_t e;
        e.res = ini; e.nvalid = 0;
        for (int l = 0; l < 8; l++) begin
            int idx = ix[l*8 +: 8];
            if (idx < 16 * (c + 1)) begin
                int el = (2 * b + (idx >> 3)) % 64;
                e.res[l*8 +: 8] = rf_mem[el][(idx & 7)*8 +: 8];
                e.nvalid++;
            end
        end
        return e;
    endfunction

    // driver: push expected item, pulse start, optionally a stray start while busy
    task automatic run_op(input logic [63:0] ix, input logic [63:0] ini,
                          input logic [4:0] b, input logic [1:0] c, input bit stray);
        exp_q.push_back(model(ix, ini, b, c));
        @(negedge clk);
        index_i = ix; init_i = ini; base_reg_i = b; reg_cnt_i = c; start_i = 1'b1;
        @(posedge clk); start_cyc = cyc + 1; rd_cnt = 0;
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R1 busy after start", {63'h0, busy_o}, 64'h1);
        if (stray) begin
            @(negedge clk);
            index_i = ~ix; init_i = ~ini; base_reg_i = b + 5'd3; start_i = 1'b1;
            @(negedge clk); start_i = 1'b0;
        end
        while (!done_o) @(negedge clk);
        @(negedge clk);
        check(done_o === 1'b0, "R2 done single cycle", {63'h0, done_o}, 64'h0);
        repeat (2) @(negedge clk);
    endtask

    // monitor: pop and compare when done appears
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                exp_t e;
                logic [63:0] snap;
                e = exp_q.pop_front();
                check(result_o === e.res, "R4/R5/R6 result", result_o, e.res);
                check(cyc - start_cyc == 8, "R2 done timing", 64'(cyc - start_cyc), 64'd8);
                check(rd_cnt == e.nvalid, "R8 read count", 64'(rd_cnt), 64'(e.nvalid));
                snap = result_o;
                @(negedge clk); @(negedge clk);
                check(result_o === snap, "R9 result held", result_o, snap);
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        check(1'b0, "watchdog expired", 64'(cyc), 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int e = 0; e < 64; e++)
            for (int k = 0; k < 8; k++)
                rf_mem[e][k*8 +: 8] = 8'((e * 29 + k * 37 + 11) ^ (k << 4));
        repeat (3) @(negedge clk);
        // R10: reset state
        check(busy_o === 0 && done_o === 0 && rf_rd_en_o === 0, "R10 reset flags",
              {61'h0, busy_o, done_o, rf_rd_en_o}, 64'h0);
        check(result_o === 64'h0, "R10 reset result", result_o, 64'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R3 boundaries with one register: 15 valid, 16 invalid; lookup form (R5 zeros)
        run_op(64'h10_0F_00_08_07_01_10_0F, 64'h0, 5'd3, 2'd0, 0);
        // R3 boundary with four registers: 63 valid, 64 invalid; extend form (R5)
        run_op(64'h40_3F_20_30_2F_1F_40_3F, 64'hDEAD_BEEF_CAFE_F00D, 5'd10, 2'd3, 0);
        // R4 wrap from register 31 to register 0
        run_op(64'h3F_30_2F_20_1F_10_08_00, 64'h1111_2222_3333_4444, 5'd31, 2'd3, 0);
        // R7 index 255 with every count
        for (int c = 0; c < 4; c++)
            run_op(64'hFF_FF_FF_FF_FF_FF_FF_FF, 64'h0123_4567_89AB_CDEF, 5'd7, 2'(c), 0);
        // R3 two and three registers
        run_op(64'h30_2F_20_1F_05_25_31_2A, 64'hAAAA_5555_AAAA_5555, 5'd30, 2'd1, 0);
        run_op(64'h30_2F_20_1F_05_25_31_2A, 64'hAAAA_5555_AAAA_5555, 5'd30, 2'd2, 0);
        // R6 repeated index in every lane
        run_op(64'h0B_0B_0B_0B_0B_0B_0B_0B, 64'h0, 5'd1, 2'd0, 0);
        // R1 stray start while busy is ignored
        run_op(64'h07_06_05_04_03_02_01_00, 64'hFFFF_FFFF_FFFF_FFFF, 5'd12, 2'd0, 1);
        check(busy_o === 1'b0, "R2 idle after done", {63'h0, busy_o}, 64'h0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule